// File: doc/BRIEF.md
# Outstanding Request Tracker with Line Aliasing

This block sits beside a processor memory port and keeps a record of every request that has been sent toward the cache hierarchy but not yet answered. The key for each request is the cache-line part of its address. Read-class requests go into one small associative table and write-class requests into another. Each new request is answered in the same cycle with one of three outcomes: issued, refused because the tracker is full, or refused because a request to the same line is already pending in either table. Each kind of conflict has its own stall counter. A completion names the line and the table it belongs to. It removes the entry and reports how many cycles the request was pending.

A periodic watchdog scans the ages of all pending entries. The first accepted request arms it. When its period runs out, it raises a sticky deadlock flag if any entry has been pending for at least the threshold. It re-arms while work is still outstanding. A completion that finds no matching entry raises a protocol-miss flag for that cycle.

Top module: `rqt_tracker`

## Requirements
- R1: After reset, `outstanding` is 0, all four stall counters are 0, `deadlock` is 0, `req_status` is idle (0) and `cmp_miss` is 0.
- R2: When `outstanding` is at or above MAX_OUT, a valid request gets status full (2). This takes priority over any alias conflict. No counter or table changes.
- R3: The line key is `addr[AW-1:OFS]`. Two addresses that differ only in their low OFS bits refer to the same line.
- R4: The kind codes are 0 load and 1 instruction fetch, which are read-class. The write-class codes are 2 store, 3 read-modify-write read, 4 read-modify-write write, 5 load-linked, 6 store-conditional, 7 locked read-modify-write read, 8 locked read-modify-write write and 9 flush. A write-class entry, flush included, is removed only by a completion with `cmp_is_write`=1.
- R5: A write-class request whose line is pending in the read table gets status alias (3), and `stall_wr_rd` increments.
- R6: A write-class request whose line is pending in the write table gets alias, and `stall_wr_wr` increments.
- R7: A read-class request whose line is pending in the write table gets alias with `stall_rd_wr` incremented. One whose line is pending in the read table gets alias with `stall_rd_rd` incremented.
- R8: An accepted request gets status issued (1). `outstanding` rises by one on the next cycle and always equals the number of valid entries in the two tables.
- R9: A matching completion removes its entry. In the same cycle, `cmp_latency` equals the completion cycle minus the request cycle.
- R10: A completion with no match in the selected table raises `cmp_miss` in that cycle and leaves `outstanding` unchanged.
- R11: `deadlock` stays 0 while every pending entry is younger than THRESH cycles. It rises within 2*THRESH+2 cycles after an entry reaches that age and then stays high until reset.
- R12: A request and a completion in the same cycle are checked against the tables as they were before the removal. A request to the line being completed is therefore refused as alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New request present |
| req_addr | input | AW | Request byte address |
| req_kind | input | 4 | Request kind code (R4) |
| req_status | output | 2 | 0 idle, 1 issued, 2 full, 3 alias (same cycle) |
| cmp_valid | input | 1 | Completion present |
| cmp_is_write | input | 1 | Completion targets the write table |
| cmp_addr | input | AW | Completion address |
| cmp_miss | output | 1 | Completion matched no entry |
| cmp_latency | output | TW | Cycles the completed request was pending |
| outstanding | output | clog2(MAX_OUT+1) | Pending request count |
| stall_wr_rd | output | CW | Writes refused behind a pending read |
| stall_wr_wr | output | CW | Writes refused behind a pending write |
| stall_rd_wr | output | CW | Reads refused behind a pending write |
| stall_rd_rd | output | CW | Reads refused behind a pending read |
| deadlock | output | 1 | Sticky deadlock flag |

## Verification
A lost or duplicated entry shows at the ports in one of two ways. The next request to that line gets the wrong status in the same cycle, or a later completion raises `cmp_miss` when it should not. A stale count shows up within one cycle, because `outstanding` then disagrees with the full/issued decision for the next request. An issue stamp that is wrong shows in `cmp_latency` in the cycle of completion. The same wrong stamp can also raise `deadlock` early or late, and that is seen within two watchdog periods.

// File: rtl/rqt_pkg.sv
package rqt_pkg;

    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_ISSUED = 2'd1,
        RS_FULL   = 2'd2,
        RS_ALIAS  = 2'd3
    } rsp_e;

    typedef enum logic [3:0] {
        K_LOAD    = 4'd0,
        K_IFETCH  = 4'd1,
        K_STORE   = 4'd2,
        K_RMW_RD  = 4'd3,
        K_RMW_WR  = 4'd4,
        K_LL      = 4'd5,
        K_SC      = 4'd6,
        K_LOCK_RD = 4'd7,
        K_LOCK_WR = 4'd8,
        K_FLUSH   = 4'd9
    } kind_e;

    localparam int TBL_RD = 0;
    localparam int TBL_WR = 1;
    localparam int N_TBL  = 2;

    function automatic logic is_read_class(input logic [3:0] kind);
        return (kind == K_LOAD) || (kind == K_IFETCH);
    endfunction

endpackage

// File: rtl/rqt_table.sv
module rqt_table #(
    parameter int DEPTH  = 4,
    parameter int LW     = 26,
    parameter int TW     = 16,
    parameter int THRESH = 64,
    parameter int OW     = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] now,
    input  logic [LW-1:0] look_line,
    output logic          look_hit,
    input  logic          ins_en,
    input  logic          rm_en,
    input  logic [LW-1:0] rm_line,
    output logic          rm_hit,
    output logic [TW-1:0] rm_age,
    output logic [OW-1:0] occ,
    output logic          stale
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] vld_q;
    logic [LW-1:0]    line_q  [DEPTH];
    logic [TW-1:0]    stamp_q [DEPTH];
    logic [DEPTH-1:0] look_vec, rm_vec, old_vec;
    logic [IW-1:0]    free_idx;

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        assign look_vec[e] = vld_q[e] && (line_q[e] == look_line);
        assign rm_vec[e]   = vld_q[e] && (line_q[e] == rm_line);
        assign old_vec[e]  = vld_q[e] && ((now - stamp_q[e]) >= TW'(THRESH));
    end

    assign look_hit = |look_vec;
    assign rm_hit   = |rm_vec;
    assign stale    = |old_vec;

    always_comb begin
        free_idx = '0;
        rm_age   = '0;
        occ      = '0;
        for (int e = DEPTH - 1; e >= 0; e--) begin
            if (!vld_q[e]) free_idx = IW'(e);
            if (rm_vec[e]) rm_age = now - stamp_q[e];
            occ = occ + OW'(vld_q[e]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int e = 0; e < DEPTH; e++) begin
                line_q[e]  <= '0;
                stamp_q[e] <= '0;
            end
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                if (rm_en && rm_vec[e]) vld_q[e] <= 1'b0;
            end
            if (ins_en) begin
                vld_q[free_idx]   <= 1'b1;
                line_q[free_idx]  <= look_line;
                stamp_q[free_idx] <= now;
            end
        end
    end

endmodule

// File: rtl/rqt_watchdog.sv
module rqt_watchdog #(
    parameter int THRESH = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_req,
    input  logic busy,
    input  logic stale,
    output logic deadlock
);
    localparam int TMW = $clog2(THRESH + 1);

    logic           armed_q;
    logic [TMW-1:0] timer_q;
    logic           fire;

    assign fire = armed_q && (timer_q == TMW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            timer_q  <= '0;
            deadlock <= 1'b0;
        end else if (fire) begin
            if (stale) deadlock <= 1'b1;
            if (busy || arm_req) timer_q <= TMW'(THRESH);
            else                 armed_q <= 1'b0;
        end else if (armed_q) begin
            timer_q <= timer_q - TMW'(1);
        end else if (arm_req) begin
            armed_q <= 1'b1;
            timer_q <= TMW'(THRESH);
        end
    end

endmodule

// File: rtl/rqt_tracker.sv
module rqt_tracker
    import rqt_pkg::*;
#(
    parameter int AW      = 32,
    parameter int OFS     = 6,
    parameter int MAX_OUT = 4,
    parameter int THRESH  = 64,
    parameter int TW      = 16,
    parameter int CW      = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  logic [AW-1:0]                req_addr,
    input  logic [3:0]                   req_kind,
    output logic [1:0]                   req_status,
    input  logic                         cmp_valid,
    input  logic                         cmp_is_write,
    input  logic [AW-1:0]                cmp_addr,
    output logic                         cmp_miss,
    output logic [TW-1:0]                cmp_latency,
    output logic [$clog2(MAX_OUT+1)-1:0] outstanding,
    output logic [CW-1:0]                stall_wr_rd,
    output logic [CW-1:0]                stall_wr_wr,
    output logic [CW-1:0]                stall_rd_wr,
    output logic [CW-1:0]                stall_rd_rd,
    output logic                         deadlock
);
    localparam int LW = AW - OFS;
    localparam int NW = $clog2(MAX_OUT + 1);

    logic [LW-1:0] req_line, cmp_line;
    logic [TW-1:0] now_q;
    logic [NW-1:0] count_q;
    logic          rd_req, full, accept, cmp_hit;
    rsp_e          status;

    logic          look_hit [N_TBL];
    logic          rm_hit   [N_TBL];
    logic [TW-1:0] rm_age   [N_TBL];
    logic [NW-1:0] occ      [N_TBL];
    logic          stale    [N_TBL];
    logic          ins_en   [N_TBL];
    logic          rm_en    [N_TBL];
    logic [NW:0]   occ_sum;
    logic          unused_lo;

    assign req_line  = req_addr[AW-1:OFS];
    assign cmp_line  = cmp_addr[AW-1:OFS];
    assign unused_lo = ^{req_addr[OFS-1:0], cmp_addr[OFS-1:0]};
    assign occ_sum   = {1'b0, occ[TBL_RD]} + {1'b0, occ[TBL_WR]};

    assign rd_req = is_read_class(req_kind);
    assign full   = count_q >= NW'(MAX_OUT);

    always_comb begin
        if (!req_valid)                             status = RS_IDLE;
        else if (full)                              status = RS_FULL;
        else if (look_hit[TBL_RD] || look_hit[TBL_WR]) status = RS_ALIAS;
        else                                        status = RS_ISSUED;
    end

    assign accept     = (status == RS_ISSUED);
    assign req_status = status;

    for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
        assign ins_en[t] = accept && (rd_req == (t == TBL_RD));
        assign rm_en[t]  = cmp_valid && (cmp_is_write == (t == TBL_WR));
        rqt_table #(
            .DEPTH (MAX_OUT),
            .LW    (LW),
            .TW    (TW),
            .THRESH(THRESH),
            .OW    (NW)
        ) tbl_i (
            .clk      (clk),
            .rst      (rst),
            .now      (now_q),
            .look_line(req_line),
            .look_hit (look_hit[t]),
            .ins_en   (ins_en[t]),
            .rm_en    (rm_en[t]),
            .rm_line  (cmp_line),
            .rm_hit   (rm_hit[t]),
            .rm_age   (rm_age[t]),
            .occ      (occ[t]),
            .stale    (stale[t])
        );
    end

    assign cmp_hit     = cmp_is_write ? rm_hit[TBL_WR] : rm_hit[TBL_RD];
    assign cmp_miss    = cmp_valid && !cmp_hit;
    assign cmp_latency = (cmp_valid && cmp_hit)
                       ? (cmp_is_write ? rm_age[TBL_WR] : rm_age[TBL_RD]) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            now_q       <= '0;
            count_q     <= '0;
            stall_wr_rd <= '0;
            stall_wr_wr <= '0;
            stall_rd_wr <= '0;
            stall_rd_rd <= '0;
        end else begin
            now_q   <= now_q + TW'(1);
            count_q <= count_q + NW'(accept) - NW'(cmp_valid && cmp_hit);
            if (status == RS_ALIAS) begin
                if (rd_req) begin
                    if (look_hit[TBL_WR]) stall_rd_wr <= stall_rd_wr + CW'(1);
                    else                  stall_rd_rd <= stall_rd_rd + CW'(1);
                end else begin
                    if (look_hit[TBL_RD]) stall_wr_rd <= stall_wr_rd + CW'(1);
                    else                  stall_wr_wr <= stall_wr_wr + CW'(1);
                end
            end
        end
    end

    assign outstanding = count_q;

    rqt_watchdog #(.THRESH(THRESH)) wd_i (
        .clk     (clk),
        .rst     (rst),
        .arm_req (accept),
        .busy    (count_q != '0),
        .stale   (stale[TBL_RD] || stale[TBL_WR]),
        .deadlock(deadlock)
    );

endmodule

// File: rtl/rqt_tracker_chk.sv
module rqt_tracker_chk #(
    parameter int MAX_OUT = 4,
    parameter int NW      = 3,
    parameter int CW      = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic [1:0]    req_status,
    input logic          cmp_valid,
    input logic          cmp_miss,
    input logic [NW-1:0] outstanding,
    input logic [NW:0]   occ_sum,
    input logic [CW-1:0] stall_wr_rd,
    input logic [CW-1:0] stall_wr_wr,
    input logic [CW-1:0] stall_rd_wr,
    input logic [CW-1:0] stall_rd_rd,
    input logic          deadlock
);
    // R2: full refusal before any alias decision
    a_r2_full_first: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (int'(outstanding) >= MAX_OUT)) |-> (req_status == 2'd2));

    // R8: counter agrees with the table occupancy
    a_r8_count_tracks_tables: assert property (@(posedge clk) disable iff (rst)
        int'(occ_sum) == int'(outstanding));

    // R8 / R10: count moves only by accepts and matched completions
    a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (int'(outstanding) == int'($past(outstanding))
            + int'($past(req_status == 2'd1))
            - int'($past(cmp_valid && !cmp_miss))));

    // R10: nothing pending means any completion misses
    a_r10_empty_miss: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && (outstanding == '0)) |-> cmp_miss);

    // R5 / R6 / R7: stall counters move only on an alias refusal
    a_r7_counters_quiet: assert property (@(posedge clk) disable iff (rst)
        (req_status != 2'd3) |=> $stable({stall_wr_rd, stall_wr_wr, stall_rd_wr, stall_rd_rd}));

    // R11: deadlock flag is sticky
    a_r11_deadlock_sticky: assert property (@(posedge clk) disable iff (rst)
        deadlock |=> deadlock);

endmodule

bind rqt_tracker rqt_tracker_chk #(
    .MAX_OUT(MAX_OUT),
    .NW     (NW),
    .CW     (CW)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_status (req_status),
    .cmp_valid  (cmp_valid),
    .cmp_miss   (cmp_miss),
    .outstanding(outstanding),
    .occ_sum    (occ_sum),
    .stall_wr_rd(stall_wr_rd),
    .stall_wr_wr(stall_wr_wr),
    .stall_rd_wr(stall_rd_wr),
    .stall_rd_rd(stall_rd_rd),
    .deadlock   (deadlock)
);

// File: tb/rqt_tracker_tb_top.sv
`timescale 1ns/1ps
module rqt_tracker_tb_top;
    localparam int AW = 32, OFS = 6, MAX_OUT = 4, THRESH = 64, TW = 16, CW = 16;
    localparam int NW = $clog2(MAX_OUT + 1);
    localparam int ST_IDLE = 0, ST_ISS = 1, ST_FULL = 2, ST_ALIAS = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_kind = '0;
    logic [1:0]    req_status;
    logic          cmp_valid = 1'b0;
    logic          cmp_is_write = 1'b0;
    logic [AW-1:0] cmp_addr = '0;
    logic          cmp_miss;
    logic [TW-1:0] cmp_latency;
    logic [NW-1:0] outstanding;
    logic [CW-1:0] stall_wr_rd, stall_wr_wr, stall_rd_wr, stall_rd_rd;
    logic          deadlock;

    always #4 clk = ~clk;

    rqt_tracker #(.AW(AW), .OFS(OFS), .MAX_OUT(MAX_OUT), .THRESH(THRESH),
                  .TW(TW), .CW(CW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .req_status(req_status), .cmp_valid(cmp_valid),
        .cmp_is_write(cmp_is_write), .cmp_addr(cmp_addr), .cmp_miss(cmp_miss),
        .cmp_latency(cmp_latency), .outstanding(outstanding),
        .stall_wr_rd(stall_wr_rd), .stall_wr_wr(stall_wr_wr),
        .stall_rd_wr(stall_rd_wr), .stall_rd_rd(stall_rd_rd), .deadlock(deadlock));

    int nchk = 0, nfail = 0, cyc = 0;
    int    exp_st_q[$];
    string exp_st_tag[$];
    int    exp_miss_q[$];
    int    exp_lat_q[$];
    string exp_cmp_tag[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: compares each same-cycle response against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (req_valid && exp_st_q.size() > 0)
                chk(exp_st_tag.pop_front(), int'(req_status), exp_st_q.pop_front());
            if (cmp_valid && exp_miss_q.size() > 0) begin
                automatic string t = exp_cmp_tag.pop_front();
                automatic int em = exp_miss_q.pop_front();
                automatic int el = exp_lat_q.pop_front();
                chk({t, " miss"}, int'(cmp_miss), em);
                if (em == 0) chk({t, " latency"}, int'(cmp_latency), el);
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        cmp_valid = 1'b0;
    endtask

    task automatic send_req(input logic [31:0] a, input logic [3:0] k,
                            input int exp, input string tag, output int at);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_kind = k;
        cmp_valid = 1'b0;
        exp_st_q.push_back(exp); exp_st_tag.push_back(tag);
        at = cyc;
    endtask

    task automatic send_cmp(input logic wr, input logic [31:0] a, input int issued,
                            input int exp_miss, input string tag);
        @(negedge clk);
        req_valid = 1'b0;
        cmp_valid = 1'b1; cmp_is_write = wr; cmp_addr = a;
        exp_miss_q.push_back(exp_miss);
        exp_lat_q.push_back(cyc - issued);
        exp_cmp_tag.push_back(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int ta, tb, tc, td, tx;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        chk("R1 outstanding", int'(outstanding), 0);
        chk("R1 stalls", int'(stall_wr_rd | stall_wr_wr | stall_rd_wr | stall_rd_rd), 0);
        chk("R1 deadlock", int'(deadlock), 0);
        chk("R1 status idle", int'(req_status), ST_IDLE);
        chk("R1 cmp_miss", int'(cmp_miss), 0);

        send_req(32'h1000, 4'd0, ST_ISS, "R8 load A issued", ta);
        idle(); #1;
        chk("R8 count after A", int'(outstanding), 1);
        // same line, different offset: R3 and R5
        send_req(32'h1004, 4'd2, ST_ALIAS, "R5 store behind read", tx);
        send_req(32'h103c, 4'd1, ST_ALIAS, "R7 ifetch behind read (R3)", tx);
        idle(); #1;
        chk("R5 stall_wr_rd", int'(stall_wr_rd), 1);
        chk("R7 stall_rd_rd", int'(stall_rd_rd), 1);
        chk("R8 count unchanged by alias", int'(outstanding), 1);

        send_req(32'h2000, 4'd9, ST_ISS, "R4 flush issued", tb);
        send_req(32'h2008, 4'd0, ST_ALIAS, "R7 load behind flush", tx);
        send_req(32'h2010, 4'd5, ST_ALIAS, "R6 ll behind write", tx);
        idle(); #1;
        chk("R7 stall_rd_wr", int'(stall_rd_wr), 1);
        chk("R6 stall_wr_wr", int'(stall_wr_wr), 1);
        chk("R8 count 2", int'(outstanding), 2);

        send_req(32'h3000, 4'd3, ST_ISS, "R4 rmw read issued", tc);
        send_req(32'h4000, 4'd1, ST_ISS, "R4 ifetch issued", td);
        idle(); #1;
        chk("R8 count 4", int'(outstanding), 4);
        send_req(32'h5000, 4'd0, ST_FULL, "R2 full new line", tx);
        send_req(32'h1000, 4'd2, ST_FULL, "R2 full beats alias", tx);
        idle(); #1;
        chk("R2 stall_wr_rd unchanged", int'(stall_wr_rd), 1);
        chk("R2 count unchanged", int'(outstanding), 4);

        send_cmp(1'b0, 32'h1020, ta, 0, "R9 complete A");
        idle(); #1;
        chk("R9 count after A", int'(outstanding), 3);
        send_cmp(1'b1, 32'h1000, 0, 1, "R10 write table miss");
        idle(); #1;
        chk("R10 count unchanged", int'(outstanding), 3);
        send_cmp(1'b0, 32'h2000, 0, 1, "R4 flush not in read table");
        idle(); #1;
        chk("R4 count unchanged", int'(outstanding), 3);

        // R12: completion of B and load to B in the same cycle
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h2004; req_kind = 4'd0;
        cmp_valid = 1'b1; cmp_is_write = 1'b1; cmp_addr = 32'h2000;
        exp_st_q.push_back(ST_ALIAS); exp_st_tag.push_back("R12 alias on same-cycle completion");
        exp_miss_q.push_back(0); exp_lat_q.push_back(cyc - tb);
        exp_cmp_tag.push_back("R4 flush completes");
        idle(); #1;
        chk("R12 stall_rd_wr", int'(stall_rd_wr), 2);
        chk("R12 count", int'(outstanding), 2);

        send_cmp(1'b1, 32'h3000, tc, 0, "R9 complete C");
        send_cmp(1'b0, 32'h4000, td, 0, "R9 complete D");
        idle(); #1;
        chk("R8 count drained", int'(outstanding), 0);
        send_cmp(1'b0, 32'h4000, 0, 1, "R10 completion when empty");
        idle(); #1;
        chk("R10 count stays 0", int'(outstanding), 0);

        send_req(32'h6000, 4'd2, ST_ISS, "R11 stuck store", tx);
        idle();
        repeat (40) @(negedge clk);
        #1;
        chk("R11 no deadlock while young", int'(deadlock), 0);
        repeat (140) @(negedge clk);
        #1;
        chk("R11 deadlock raised", int'(deadlock), 1);
        send_cmp(1'b1, 32'h6000, tx, 0, "R9 late completion");
        idle();
        repeat (3) @(negedge clk);
        #1;
        chk("R11 deadlock sticky", int'(deadlock), 1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule